// File: doc/BRIEF.md
# Configurable Synchronous Burst Read Sequencer

This block sequences synchronous burst reads from a memory array. It keeps a small configuration register. The register selects between synchronous burst reads and an asynchronous mode. It also sets when the ready indication comes relative to data, the burst wrap length or an unbounded continuous burst, and the number of clock edges from the address strobe to the first data word. It also stores an output-edge selection, which it only reports. The register is loaded from a fixed field of the address bus while a configuration strobe is high.

When synchronous mode is selected, the address strobe captures a starting word address. After the strobe drops, the block counts rising clock edges. On the programmed edge it raises the data-valid output with the starting address on the array address output. On each later edge it steps the address to the next word. In a wrapped mode the step stays inside an aligned block of 8, 16 or 32 words. In continuous mode the address simply increments. The ready output either tracks data-valid or rises one cycle before it. In asynchronous mode, burst starts are ignored and ready stays high.

Top module: `sync_burst_seq`

## Requirements
- R1: After reset, the configuration is: asynchronous mode, ready with data, rising edge, continuous burst and wait code 101. The outputs are then rdy=1, dataValid=0 and edgeRising=1.
- R2: When cfgWrite is high at a rising edge, the configuration is loaded from addrIn. Bit 19 selects the mode (0 synchronous, 1 asynchronous). Bit 18 selects ready timing (1 with data, 0 one cycle early). Bit 17 selects the edge (1 rising, 0 falling). Bits 16:15 select the burst kind (00 continuous, 01 wrap 8, 10 wrap 16, 11 wrap 32). Bits 14:12 hold the wait code.
- R3: In synchronous mode, addrValid high at a rising edge captures addrIn as the start address. dataValid first reads high in the cycle after the N-th rising edge at which addrValid is sampled low, where N = wait code + 2. At that point arrayAddr equals the start address.
- R4: With ready-with-data selected, rdy equals dataValid in synchronous mode. With early ready selected, rdy rises one cycle before dataValid and stays high with it.
- R5: In asynchronous mode, addrValid has no effect: dataValid stays 0 and rdy stays 1.
- R6: In continuous mode, arrayAddr increments by one on every edge after first data. It rolls over from all ones to zero.
- R7: In a wrapped mode, arrayAddr increments only within the aligned block of 8, 16 or 32 words. It returns to the block start after the last word, and the bits above the block stay unchanged.
- R8: Wait codes 110 and 111 give the same latency as 101 (N = 7).
- R9: Output edgeRising reports the stored edge bit. It has no effect on data timing.
- R10: cfgWrite ends any burst in progress. When cfgWrite and addrValid are high in the same cycle, the configuration is loaded and no burst starts.
- R11: addrValid during a burst restarts it: dataValid drops, and the new start address and the latency count begin again.
- R12: Once dataValid is high, it stays high on every cycle until a restart or a configuration write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edges are the counted edges |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWrite | input | 1 | Configuration write strobe |
| addrIn | input | ADDR_W | Start address, or configuration field at bits 19:12 |
| addrValid | input | 1 | Address strobe that starts a burst |
| arrayAddr | output | ADDR_W | Word address presented to the array |
| dataValid | output | 1 | High while a data word is being delivered |
| rdy | output | 1 | Ready indication to the bus master |
| edgeRising | output | 1 | Stored output-edge selection (1 rising) |

## Verification
The two functions that can meet in one cycle are a configuration write and a burst start, since both are strobes sampled on the same edge. The bench starts a burst, waits for its data phase, then raises cfgWrite and addrValid together. It judges that the new configuration took effect, that dataValid dropped, and that no burst followed. A following burst then shows the new latency. A second collision, a fresh address strobe during a data phase, is judged by dataValid dropping and the new latency count running from the new strobe.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

  // Field order matches the decoded address bits, high to low.
  typedef struct packed {
    logic       asyncMode;
    logic       rdyWithData;
    logic       risingEdge;
    logic [1:0] burstKind;
    logic [2:0] waitCode;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  localparam cfg_t CFG_RESET = '{
    asyncMode:   1'b1,
    rdyWithData: 1'b1,
    risingEdge:  1'b1,
    burstKind:   2'b00,
    waitCode:    3'b101
  };

  typedef struct packed {
    logic load;
    logic advance;
  } strobe_t;

  function automatic logic [2:0] firstDataEdge(input logic [2:0] code);
    if (code > 3'd5) return 3'd7;
    return code + 3'd2;
  endfunction

  function automatic logic [4:0] wrapMask(input logic [1:0] kind);
    case (kind)
      2'b01:   return 5'd7;
      2'b10:   return 5'd15;
      2'b11:   return 5'd31;
      default: return 5'd0;
    endcase
  endfunction

endpackage

// File: rtl/bsq_cfg_reg.sv
module bsq_cfg_reg
  import bsq_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int CFG_LSB = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrite,
  input  logic [ADDR_W-1:0] addrIn,
  output cfg_t              cfgQ
);

  localparam int CFG_MSB = CFG_LSB + CFG_W - 1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         cfgQ <= CFG_RESET;
    else if (cfgWrite) cfgQ <= cfg_t'(addrIn[CFG_MSB:CFG_LSB]);
  end

endmodule

// File: rtl/bsq_ctrl.sv
module bsq_ctrl
  import bsq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  cfg_t    cfgQ,
  input  logic    cfgWrite,
  input  logic    addrValid,
  output strobe_t strobe,
  output logic    dataValid,
  output logic    rdy
);

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_DATA} state_t;

  state_t     state;
  logic [2:0] edgeCnt;
  logic [2:0] edgeCntNext;
  logic [2:0] latency;
  logic       dvQ;
  logic       rdyQ;
  logic       startReq;

  assign latency     = firstDataEdge(cfgQ.waitCode);
  assign edgeCntNext = edgeCnt + 3'd1;
  assign startReq    = addrValid && !cfgWrite && !cfgQ.asyncMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      edgeCnt <= '0;
      dvQ     <= 1'b0;
      rdyQ    <= 1'b0;
    end else if (cfgWrite || cfgQ.asyncMode) begin
      state   <= ST_IDLE;
      edgeCnt <= '0;
      dvQ     <= 1'b0;
      rdyQ    <= 1'b0;
    end else if (startReq) begin
      state   <= ST_WAIT;
      edgeCnt <= '0;
      dvQ     <= 1'b0;
      rdyQ    <= 1'b0;
    end else begin
      case (state)
        ST_WAIT: begin
          edgeCnt <= edgeCntNext;
          if (edgeCntNext == latency) begin
            state <= ST_DATA;
            dvQ   <= 1'b1;
            rdyQ  <= 1'b1;
          end else if (!cfgQ.rdyWithData && (edgeCntNext == latency - 3'd1)) begin
            rdyQ  <= 1'b1;
          end
        end
        ST_DATA: begin
          dvQ  <= 1'b1;
          rdyQ <= 1'b1;
        end
        default: begin
          dvQ  <= 1'b0;
          rdyQ <= 1'b0;
        end
      endcase
    end
  end

  assign strobe.load    = startReq;
  assign strobe.advance = (state == ST_DATA) && !addrValid && !cfgWrite;
  assign dataValid      = dvQ;
  assign rdy            = cfgQ.asyncMode ? 1'b1 : rdyQ;

endmodule

// File: rtl/bsq_datapath.sv
module bsq_datapath
  import bsq_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [1:0]        burstKind,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] arrayAddr
);

  localparam int MASK_W = 5;

  logic [ADDR_W-1:0] addrQ;
  logic [ADDR_W-1:0] incr;
  logic [ADDR_W-1:0] blockMask;
  logic [ADDR_W-1:0] nextAddr;

  assign blockMask = {{(ADDR_W-MASK_W){1'b0}}, wrapMask(burstKind)};
  assign incr      = addrQ + {{(ADDR_W-1){1'b0}}, 1'b1};

  always_comb begin
    if (burstKind == 2'b00) nextAddr = incr;
    else                    nextAddr = (addrQ & ~blockMask) | (incr & blockMask);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               addrQ <= '0;
    else if (strobe.load)    addrQ <= addrIn;
    else if (strobe.advance) addrQ <= nextAddr;
  end

  assign arrayAddr = addrQ;

endmodule

// File: rtl/sync_burst_seq.sv
module sync_burst_seq
  import bsq_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int CFG_LSB = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrite,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              addrValid,
  output logic [ADDR_W-1:0] arrayAddr,
  output logic              dataValid,
  output logic              rdy,
  output logic              edgeRising
);

  cfg_t    cfgQ;
  strobe_t strobe;

  bsq_cfg_reg #(.ADDR_W(ADDR_W), .CFG_LSB(CFG_LSB)) u_cfg (
    .clk(clk), .rstN(rstN), .cfgWrite(cfgWrite), .addrIn(addrIn), .cfgQ(cfgQ)
  );

  bsq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgQ(cfgQ), .cfgWrite(cfgWrite),
    .addrValid(addrValid), .strobe(strobe), .dataValid(dataValid), .rdy(rdy)
  );

  bsq_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .burstKind(cfgQ.burstKind),
    .addrIn(addrIn), .arrayAddr(arrayAddr)
  );

  assign edgeRising = cfgQ.risingEdge;

endmodule

// File: rtl/sync_burst_seq_chk.sv
module sync_burst_seq_chk
  import bsq_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgWrite,
  input logic              addrValid,
  input logic [ADDR_W-1:0] arrayAddr,
  input logic              dataValid,
  input logic              rdy,
  input logic              edgeRising,
  input cfg_t              cfgQ
);

  logic [3:0]        sinceStrobe;
  logic [3:0]        expEdge;
  logic [ADDR_W-1:0] hiMask;

  assign expEdge = (cfgQ.waitCode > 3'd5) ? 4'd7 : {1'b0, cfgQ.waitCode} + 4'd2;
  assign hiMask  = ~{{(ADDR_W-5){1'b0}},
                     (cfgQ.burstKind == 2'b11) ? 5'h1f :
                     (cfgQ.burstKind == 2'b10) ? 5'h0f : 5'h07};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  sinceStrobe <= 4'hf;
    else if (addrValid)         sinceStrobe <= 4'd0;
    else if (sinceStrobe != 4'hf) sinceStrobe <= sinceStrobe + 4'd1;
  end

  a_r3_first_data_edge: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataValid) |-> sinceStrobe == expEdge);

  a_r5_async_idle: assert property (@(posedge clk) disable iff (!rstN)
    cfgQ.asyncMode |-> (rdy && !dataValid));

  a_r4_rdy_with_data: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgQ.asyncMode && cfgQ.rdyWithData) |-> (rdy == dataValid));

  a_r4_rdy_early: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgQ.asyncMode && !cfgQ.rdyWithData && $rose(dataValid)) |-> $past(rdy));

  a_r6_cont_step: assert property (@(posedge clk) disable iff (!rstN)
    (dataValid && !addrValid && !cfgWrite && cfgQ.burstKind == 2'b00)
      |=> arrayAddr == $past(arrayAddr) + {{(ADDR_W-1){1'b0}}, 1'b1});

  a_r7_block_kept: assert property (@(posedge clk) disable iff (!rstN)
    (dataValid && !addrValid && !cfgWrite && cfgQ.burstKind != 2'b00)
      |=> (arrayAddr & hiMask) == ($past(arrayAddr) & $past(hiMask)));

  a_r10_cfg_cancels: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrite |=> !dataValid);

  a_r12_dv_holds: assert property (@(posedge clk) disable iff (!rstN)
    (dataValid && !addrValid && !cfgWrite) |=> dataValid);

  a_r9_edge_report: assert property (@(posedge clk) disable iff (!rstN)
    edgeRising == cfgQ.risingEdge);

endmodule

bind sync_burst_seq sync_burst_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .cfgWrite(cfgWrite), .addrValid(addrValid),
  .arrayAddr(arrayAddr), .dataValid(dataValid), .rdy(rdy),
  .edgeRising(edgeRising), .cfgQ(cfgQ)
);

// File: tb/sync_burst_seq_bench.sv
module sync_burst_seq_bench;

  localparam int  ADDR_W = 20;
  localparam time CLK_PERIOD = 10ns;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cfgWrite = 1'b0;
  logic [ADDR_W-1:0] addrIn = '0;
  logic              addrValid = 1'b0;
  logic [ADDR_W-1:0] arrayAddr;
  logic              dataValid;
  logic              rdy;
  logic              edgeRising;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_burst_seq #(.ADDR_W(ADDR_W)) u_sync_burst_seq (
    .clk(clk), .rstN(rstN), .cfgWrite(cfgWrite), .addrIn(addrIn),
    .addrValid(addrValid), .arrayAddr(arrayAddr), .dataValid(dataValid),
    .rdy(rdy), .edgeRising(edgeRising)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Configuration word: bit19 async, bit18 rdy-with-data, bit17 rising, 16:15 burst, 14:12 wait
  function automatic logic [ADDR_W-1:0] cfgWord(input logic asyncM, input logic rdyWith,
      input logic rising, input logic [1:0] kind, input logic [2:0] ws);
    return ADDR_W'({asyncM, rdyWith, rising, kind, ws}) << 12;
  endfunction

  task automatic writeCfg(input logic [ADDR_W-1:0] w);
    @(negedge clk); cfgWrite = 1'b1; addrIn = w;
    @(negedge clk); cfgWrite = 1'b0;
  endtask

  task automatic startBurst(input logic [ADDR_W-1:0] a);
    @(negedge clk); addrValid = 1'b1; addrIn = a;
    @(negedge clk); addrValid = 1'b0;
  endtask

  // Follows a burst edge by edge; mask 0 means continuous.
  task automatic runBurst(input string req, input logic [ADDR_W-1:0] start, input int n,
      input bit early, input logic [ADDR_W-1:0] mask, input int cycles);
    for (int i = 1; i <= cycles; i++) begin
      logic [ADDR_W-1:0] off;
      logic [ADDR_W-1:0] expA;
      @(posedge clk); @(negedge clk);
      chk("R3/R12", "dataValid", dataValid, (i >= n));
      chk("R4", "rdy", rdy, early ? (i >= n - 1) : (i >= n));
      if (i >= n) begin
        off  = ADDR_W'(i - n);
        expA = (mask == '0) ? start + off : (start & ~mask) | ((start + off) & mask);
        chk(req, "arrayAddr", arrayAddr, expA);
      end
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "rdy", rdy, 1);
    chk("R1", "dataValid", dataValid, 0);
    chk("R1", "edgeRising", edgeRising, 1);
  endtask

  task automatic t_async_ignored();
    startBurst(20'h00100);
    for (int i = 0; i < 10; i++) begin
      @(posedge clk); @(negedge clk);
      chk("R5", "dataValid", dataValid, 0);
      chk("R5", "rdy", rdy, 1);
    end
  endtask

  task automatic t_continuous();
    writeCfg(cfgWord(0, 1, 1, 2'b00, 3'b000));
    chk("R2", "rdy idle sync", rdy, 0);
    startBurst(20'h0001E);
    runBurst("R6", 20'h0001E, 2, 0, '0, 8);
    startBurst(20'hFFFFE);
    runBurst("R6", 20'hFFFFE, 2, 0, '0, 6);
  endtask

  task automatic t_wrap8_default_wait();
    writeCfg(cfgWord(0, 1, 1, 2'b01, 3'b101));
    startBurst(20'h00105);
    runBurst("R7", 20'h00105, 7, 0, 20'h7, 16);
  endtask

  task automatic t_wrap16_early();
    writeCfg(cfgWord(0, 0, 1, 2'b10, 3'b011));
    startBurst(20'h0ABCD);
    runBurst("R7", 20'h0ABCD, 5, 1, 20'hF, 24);
  endtask

  task automatic t_wrap32_long_codes();
    writeCfg(cfgWord(0, 1, 1, 2'b11, 3'b111));
    startBurst(20'h0033C);
    runBurst("R8", 20'h0033C, 7, 0, 20'h1F, 14);
    writeCfg(cfgWord(0, 0, 1, 2'b11, 3'b110));
    startBurst(20'h00021);
    runBurst("R8", 20'h00021, 7, 1, 20'h1F, 10);
  endtask

  task automatic t_falling_edge_reported();
    writeCfg(cfgWord(0, 1, 0, 2'b00, 3'b001));
    chk("R9", "edgeRising", edgeRising, 0);
    startBurst(20'h00400);
    runBurst("R9", 20'h00400, 3, 0, '0, 6);
  endtask

  task automatic t_cfg_and_start_same_cycle();
    writeCfg(cfgWord(0, 1, 1, 2'b00, 3'b000));
    startBurst(20'h00500);
    runBurst("R10", 20'h00500, 2, 0, '0, 4);
    @(negedge clk);
    cfgWrite = 1'b1; addrValid = 1'b1; addrIn = cfgWord(0, 1, 1, 2'b01, 3'b010);
    @(negedge clk);
    cfgWrite = 1'b0; addrValid = 1'b0;
    chk("R10", "dataValid after collision", dataValid, 0);
    chk("R10", "rdy after collision", rdy, 0);
    for (int i = 0; i < 10; i++) begin
      @(posedge clk); @(negedge clk);
      chk("R10", "no burst started", dataValid, 0);
    end
    startBurst(20'h0060E);
    runBurst("R10", 20'h0060E, 4, 0, 20'h7, 8);
  endtask

  task automatic t_restart();
    writeCfg(cfgWord(0, 1, 1, 2'b00, 3'b001));
    startBurst(20'h00700);
    runBurst("R11", 20'h00700, 3, 0, '0, 5);
    startBurst(20'h00800);
    runBurst("R11", 20'h00800, 3, 0, '0, 6);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_async_ignored();
    t_continuous();
    t_wrap8_default_wait();
    t_wrap16_early();
    t_wrap32_long_codes();
    t_falling_edge_reported();
    t_cfg_and_start_same_cycle();
    t_restart();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule